// File: doc/BRIEF.md
# Three-Level Nearest-Vector Duty Calculator

This block finds the switching triangle that surrounds a reference vector on the lattice of a three-level inverter. It also works out how long each corner of that triangle must be applied so that the time average equals the reference. The reference arrives already expressed on the 60-degree g-h axis pair, normalised to one dc step, as two signed fixed-point numbers. Each has `FRAC_W` fractional bits.

Each coordinate is split into an integer floor and a fractional remainder. The two remainders decide which half of the unit rhombus holds the reference. They also give the three duties directly, in units of 1/2^`FRAC_W` of a sampling period. No angle tables, sector decoding or multipliers are used. For the downstream sequencer, the block reports how many of the three corners sit on the outer ring of the hexagon. A ring is max(|g|,|h|,|g+h|).

A one-cycle `start` pulse captures the reference. `done` pulses in the following cycle, and the results then stay in place until the next `start`. A `start` may be given in every cycle.

Top module: `nv_duty_calc`

## Requirements
- R1: While `rst` is high, `done`, `upper_tri`, `tri_kind`, every vertex coordinate and every duty read zero.
- R2: `done` is high in exactly the cycle after a cycle with `start` high. While `start` stays low, all result outputs hold their values.
- R3: With a = g mod 1 and b = h mod 1 (both in [0,1)), and floors G, H: vertex 0 is (G + [a≠0], H) and vertex 1 is (G, H + [b≠0]).
- R4: `upper_tri` is 1 exactly when a + b ≥ 1. Vertex 2 is then (G+1, H+1); otherwise it is (G, H).
- R5: When `upper_tri` is 0, the duties are duty0 = a, duty1 = b and duty2 = 1 − a − b.
- R6: When `upper_tri` is 1, the duties are duty0 = 1 − b, duty1 = 1 − a and duty2 = a + b − 1. Neither duty0 nor duty1 is zero in this case.
- R7: The duties are non-negative and sum to exactly 2^`FRAC_W`. Σ duty_i·g_i equals the g input, and Σ duty_i·h_i equals the h input, both taken as raw integers.
- R8: A coordinate that is an exact integer still gives three valid vertices. A repeated corner carries zero duty, and no duty exceeds full scale.
- R9: `tri_kind` is 0 if any vertex has ring > 2. It is 1 if at least two vertices lie on ring 2, 2 if exactly one does, and 3 if none does.
- R10: With `start` held high in consecutive cycles, each captured reference produces its own result, one cycle later and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture `g_in`/`h_in` this cycle |
| g_in | input | COORD_W | Reference g coordinate, signed, FRAC_W fractional bits |
| h_in | input | COORD_W | Reference h coordinate, signed, FRAC_W fractional bits |
| done | output | 1 | Results valid for the previous `start` |
| v0_g | output | COORD_W-FRAC_W+1 | Vertex 0 g, signed integer |
| v0_h | output | COORD_W-FRAC_W+1 | Vertex 0 h, signed integer |
| v1_g | output | COORD_W-FRAC_W+1 | Vertex 1 g, signed integer |
| v1_h | output | COORD_W-FRAC_W+1 | Vertex 1 h, signed integer |
| v2_g | output | COORD_W-FRAC_W+1 | Vertex 2 g, signed integer |
| v2_h | output | COORD_W-FRAC_W+1 | Vertex 2 h, signed integer |
| duty0 | output | FRAC_W+1 | Duty of vertex 0, full scale 2^FRAC_W |
| duty1 | output | FRAC_W+1 | Duty of vertex 1 |
| duty2 | output | FRAC_W+1 | Duty of vertex 2 |
| upper_tri | output | 1 | Upper half of the unit rhombus selected |
| tri_kind | output | 2 | Triangle class (0 outside, 1 two outer, 2 one outer, 3 inner) |

## Verification
Two things can happen in the same cycle: the result of one reference is presented on `done`, and the next reference is captured. The bench provokes this by streaming a full grid of references with `start` held high continuously. At each falling edge it judges the outputs against the reference given one cycle earlier, so any result that is lost, repeated or mixed with the following reference is reported. A separate phase lowers `start` and changes the inputs, then confirms that `done` falls and that every result stays at the last computed value.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

    typedef enum logic [1:0] {
        TRI_OUTSIDE   = 2'd0,
        TRI_TWO_OUTER = 2'd1,
        TRI_ONE_OUTER = 2'd2,
        TRI_INNER     = 2'd3
    } tri_kind_e;

    localparam int OUTER_RING = 2;

    // Hexagonal distance of a lattice point from the origin on the g-h axes.
    function automatic int hex_ring(input int g, input int h);
        int ag;
        int ah;
        int as;
        int m;
        ag = (g < 0) ? -g : g;
        ah = (h < 0) ? -h : h;
        as = ((g + h) < 0) ? -(g + h) : (g + h);
        m  = (ag > ah) ? ag : ah;
        return (as > m) ? as : m;
    endfunction

endpackage

// File: rtl/nvc_split.sv
module nvc_split #(
    parameter int COORD_W = 8,
    parameter int FRAC_W  = 4,
    localparam int VW     = COORD_W - FRAC_W + 1
) (
    input  logic signed [COORD_W-1:0] coord,
    output logic signed [VW-1:0]      flo,
    output logic [FRAC_W-1:0]         frac
);
    // Arithmetic shift gives the floor; one extra bit leaves room for floor+1.
    assign flo  = {coord[COORD_W-1], coord[COORD_W-1:FRAC_W]};
    assign frac = coord[FRAC_W-1:0];
endmodule

// File: rtl/nvc_triangle.sv
module nvc_triangle #(
    parameter int COORD_W = 8,
    parameter int FRAC_W  = 4,
    localparam int VW     = COORD_W - FRAC_W + 1,
    localparam int DW     = FRAC_W + 1
) (
    input  logic signed [VW-1:0] flo_g,
    input  logic signed [VW-1:0] flo_h,
    input  logic [FRAC_W-1:0]    frac_g,
    input  logic [FRAC_W-1:0]    frac_h,
    output logic signed [VW-1:0] vert_g [3],
    output logic signed [VW-1:0] vert_h [3],
    output logic [DW-1:0]        duty   [3],
    output logic                 upper
);
    localparam logic [DW-1:0]        FULL = {1'b1, {FRAC_W{1'b0}}};
    localparam logic signed [VW-1:0] ONE  = VW'(1);

    logic [DW-1:0]        fa;
    logic [DW-1:0]        fb;
    logic [DW-1:0]        fsum;
    logic signed [VW-1:0] step_g;
    logic signed [VW-1:0] step_h;

    assign fa     = {1'b0, frac_g};
    assign fb     = {1'b0, frac_h};
    assign fsum   = fa + fb;
    assign upper  = fsum[FRAC_W];
    assign step_g = (|frac_g) ? ONE : '0;
    assign step_h = (|frac_h) ? ONE : '0;

    always_comb begin
        vert_g[0] = flo_g + step_g;
        vert_h[0] = flo_h;
        vert_g[1] = flo_g;
        vert_h[1] = flo_h + step_h;
        if (upper) begin
            vert_g[2] = flo_g + ONE;
            vert_h[2] = flo_h + ONE;
            duty[0]   = FULL - fb;
            duty[1]   = FULL - fa;
            duty[2]   = fsum - FULL;
        end else begin
            vert_g[2] = flo_g;
            vert_h[2] = flo_h;
            duty[0]   = fa;
            duty[1]   = fb;
            duty[2]   = FULL - fsum;
        end
    end
endmodule

// File: rtl/nvc_classify.sv
module nvc_classify #(
    parameter int VW = 5
) (
    input  logic signed [VW-1:0] vert_g [3],
    input  logic signed [VW-1:0] vert_h [3],
    output nvc_pkg::tri_kind_e   kind
);
    import nvc_pkg::*;

    logic [2:0] on_outer;
    logic [2:0] beyond;

    for (genvar i = 0; i < 3; i++) begin : g_ring
        int ring;
        assign ring        = hex_ring(int'(vert_g[i]), int'(vert_h[i]));
        assign on_outer[i] = (ring == OUTER_RING);
        assign beyond[i]   = (ring > OUTER_RING);
    end

    always_comb begin
        if (|beyond)                        kind = TRI_OUTSIDE;
        else if ($countones(on_outer) >= 2) kind = TRI_TWO_OUTER;
        else if (|on_outer)                 kind = TRI_ONE_OUTER;
        else                                kind = TRI_INNER;
    end
endmodule

// File: rtl/nv_duty_calc.sv
module nv_duty_calc #(
    parameter int COORD_W = 8,
    parameter int FRAC_W  = 4,
    localparam int VW     = COORD_W - FRAC_W + 1,
    localparam int DW     = FRAC_W + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic signed [COORD_W-1:0] g_in,
    input  logic signed [COORD_W-1:0] h_in,
    output logic                      done,
    output logic signed [VW-1:0]      v0_g,
    output logic signed [VW-1:0]      v0_h,
    output logic signed [VW-1:0]      v1_g,
    output logic signed [VW-1:0]      v1_h,
    output logic signed [VW-1:0]      v2_g,
    output logic signed [VW-1:0]      v2_h,
    output logic [DW-1:0]             duty0,
    output logic [DW-1:0]             duty1,
    output logic [DW-1:0]             duty2,
    output logic                      upper_tri,
    output logic [1:0]                tri_kind
);
    import nvc_pkg::*;

    localparam logic [DW+1:0] FULL_W = (DW+2)'(1) << FRAC_W;

    logic signed [COORD_W-1:0] axis_in [2];
    logic signed [VW-1:0]      axis_flo [2];
    logic [FRAC_W-1:0]         axis_frac [2];

    assign axis_in[0] = g_in;
    assign axis_in[1] = h_in;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        nvc_split #(.COORD_W(COORD_W), .FRAC_W(FRAC_W)) u_split (
            .coord (axis_in[a]),
            .flo   (axis_flo[a]),
            .frac  (axis_frac[a])
        );
    end

    logic signed [VW-1:0] c_vg [3];
    logic signed [VW-1:0] c_vh [3];
    logic [DW-1:0]        c_duty [3];
    logic                 c_upper;
    tri_kind_e            c_kind;

    nvc_triangle #(.COORD_W(COORD_W), .FRAC_W(FRAC_W)) u_tri (
        .flo_g  (axis_flo[0]),
        .flo_h  (axis_flo[1]),
        .frac_g (axis_frac[0]),
        .frac_h (axis_frac[1]),
        .vert_g (c_vg),
        .vert_h (c_vh),
        .duty   (c_duty),
        .upper  (c_upper)
    );

    nvc_classify #(.VW(VW)) u_cls (
        .vert_g (c_vg),
        .vert_h (c_vh),
        .kind   (c_kind)
    );

    tri_kind_e kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            v0_g      <= '0;
            v0_h      <= '0;
            v1_g      <= '0;
            v1_h      <= '0;
            v2_g      <= '0;
            v2_h      <= '0;
            duty0     <= '0;
            duty1     <= '0;
            duty2     <= '0;
            upper_tri <= 1'b0;
            kind_q    <= TRI_OUTSIDE;
        end else begin
            done <= start;
            if (start) begin
                v0_g      <= c_vg[0];
                v0_h      <= c_vh[0];
                v1_g      <= c_vg[1];
                v1_h      <= c_vh[1];
                v2_g      <= c_vg[2];
                v2_h      <= c_vh[2];
                duty0     <= c_duty[0];
                duty1     <= c_duty[1];
                duty2     <= c_duty[2];
                upper_tri <= c_upper;
                kind_q    <= c_kind;
            end
        end
    end

    assign tri_kind = kind_q;

    // Results stay put between captures.
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(duty0) && $stable(duty1) && $stable(duty2) &&
                    $stable(v2_g) && $stable(v2_h) && $stable(upper_tri)));

    // Duties always make up exactly one sampling period.
    assert_unit_sum_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (({2'b0, duty0} + {2'b0, duty1} + {2'b0, duty2}) == FULL_W));

    // Lower triangle: apex shares g with vertex 1 and h with vertex 0.
    assert_lower_apex_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !upper_tri) |-> (v2_g == v1_g && v2_h == v0_h));

    // Upper triangle: apex shares g with vertex 0 and h with vertex 1.
    assert_upper_apex_R4: assert property (@(posedge clk) disable iff (rst)
        (done && upper_tri) |-> (v2_g == v0_g && v2_h == v1_h));

    // Upper triangle needs both remainders nonzero, so the side duties are live.
    assert_upper_live_R6: assert property (@(posedge clk) disable iff (rst)
        (done && upper_tri) |-> (duty0 != '0 && duty1 != '0));

    // No duty may exceed full scale.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ({2'b0, duty0} <= FULL_W && {2'b0, duty1} <= FULL_W &&
                  {2'b0, duty2} <= FULL_W));

endmodule

// File: tb/tb_nv_duty_calc.sv
module tb_nv_duty_calc;
    localparam int CW = 8;
    localparam int FW = 4;
    localparam int VW = CW - FW + 1;
    localparam int DW = FW + 1;
    localparam int ONE = 1 << FW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [CW-1:0] g_in = '0;
    logic signed [CW-1:0] h_in = '0;
    logic done;
    logic signed [VW-1:0] v0_g, v0_h, v1_g, v1_h, v2_g, v2_h;
    logic [DW-1:0] duty0, duty1, duty2;
    logic upper_tri;
    logic [1:0] tri_kind;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    nv_duty_calc #(.COORD_W(CW), .FRAC_W(FW)) dut (
        .clk(clk), .rst(rst), .start(start), .g_in(g_in), .h_in(h_in),
        .done(done), .v0_g(v0_g), .v0_h(v0_h), .v1_g(v1_g), .v1_h(v1_h),
        .v2_g(v2_g), .v2_h(v2_h), .duty0(duty0), .duty1(duty1), .duty2(duty2),
        .upper_tri(upper_tri), .tri_kind(tri_kind)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ring_of(input int g, input int h);
        int m;
        m = (g < 0) ? -g : g;
        if (((h < 0) ? -h : h) > m) m = (h < 0) ? -h : h;
        if (((g + h < 0) ? -(g + h) : (g + h)) > m) m = (g + h < 0) ? -(g + h) : (g + h);
        return m;
    endfunction

    // Compare all result ports with values computed from the requirements.
    task automatic check_point(input int g, input int h, input int exp_done);
        int a, b, fg, fh, up;
        int eg[3], eh[3], ed[3];
        int outer, far, kind, sg, sh;
        a  = ((g % ONE) + ONE) % ONE;
        b  = ((h % ONE) + ONE) % ONE;
        fg = (g - a) / ONE;
        fh = (h - b) / ONE;
        up = (a + b >= ONE) ? 1 : 0;
        eg[0] = fg + ((a != 0) ? 1 : 0); eh[0] = fh;
        eg[1] = fg;                      eh[1] = fh + ((b != 0) ? 1 : 0);
        eg[2] = up ? fg + 1 : fg;        eh[2] = up ? fh + 1 : fh;
        if (up != 0) begin
            ed[0] = ONE - b; ed[1] = ONE - a; ed[2] = a + b - ONE;
        end else begin
            ed[0] = a; ed[1] = b; ed[2] = ONE - a - b;
        end
        outer = 0; far = 0;
        for (int i = 0; i < 3; i++) begin
            if (ring_of(eg[i], eh[i]) == 2) outer++;
            if (ring_of(eg[i], eh[i]) > 2) far++;
        end
        kind = (far != 0) ? 0 : (outer >= 2) ? 1 : (outer == 1) ? 2 : 3;

        chk("R2/R10 done", int'(done), exp_done);
        chk("R3 v0_g", int'(v0_g), eg[0]);
        chk("R3 v0_h", int'(v0_h), eh[0]);
        chk("R3 v1_g", int'(v1_g), eg[1]);
        chk("R3 v1_h", int'(v1_h), eh[1]);
        chk("R4 upper_tri", int'(upper_tri), up);
        chk("R4 v2_g", int'(v2_g), eg[2]);
        chk("R4 v2_h", int'(v2_h), eh[2]);
        if (up != 0) begin
            chk("R6 duty0", int'(duty0), ed[0]);
            chk("R6 duty1", int'(duty1), ed[1]);
            chk("R6 duty2", int'(duty2), ed[2]);
        end else begin
            chk("R5 duty0", int'(duty0), ed[0]);
            chk("R5 duty1", int'(duty1), ed[1]);
            chk("R5 duty2", int'(duty2), ed[2]);
        end
        if (a == 0 || b == 0)
            chk("R8 no duty above full", (int'(duty0) <= ONE && int'(duty1) <= ONE &&
                                          int'(duty2) <= ONE) ? 1 : 0, 1);
        chk("R7 duty sum", int'(duty0) + int'(duty1) + int'(duty2), ONE);
        sg = int'(duty0) * int'(v0_g) + int'(duty1) * int'(v1_g) + int'(duty2) * int'(v2_g);
        sh = int'(duty0) * int'(v0_h) + int'(duty1) * int'(v1_h) + int'(duty2) * int'(v2_h);
        chk("R7 rebuild g", sg, g);
        chk("R7 rebuild h", sh, h);
        chk("R9 tri_kind", int'(tri_kind), kind);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int pg, ph;
        bit pending;
        pending = 0;
        pg = 0;
        ph = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 done", int'(done), 0);
        chk("R1 duties", int'(duty0) + int'(duty1) + int'(duty2), 0);
        chk("R1 vertices", int'(v0_g) | int'(v0_h) | int'(v1_g) | int'(v1_h) |
                           int'(v2_g) | int'(v2_h), 0);
        chk("R1 upper_tri", int'(upper_tri), 0);
        chk("R1 tri_kind", int'(tri_kind), 0);
        rst = 1'b0;

        // R10: continuous capture; each result judged while the next is taken.
        for (int g = -40; g <= 40; g++) begin
            for (int h = -40; h <= 40; h++) begin
                @(negedge clk);
                if (pending) check_point(pg, ph, 1);
                g_in = CW'(g);
                h_in = CW'(h);
                start = 1'b1;
                pg = g;
                ph = h;
                pending = 1;
            end
        end
        @(negedge clk);
        check_point(pg, ph, 1);
        start = 1'b0;

        // R2: isolated captures with gaps; results hold while inputs wander.
        for (int k = 0; k < 24; k++) begin
            int tg, th;
            tg = (k * 7) % 64 - 32;
            th = 32 - (k * 11) % 64;
            @(negedge clk);
            g_in = CW'(tg);
            h_in = CW'(th);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check_point(tg, th, 1);
            g_in = CW'(th);
            h_in = CW'(-tg - 3);
            repeat (3) @(negedge clk);
            check_point(tg, th, 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule